// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block steers the stall and flush behaviour of a four-stage in-order pipeline (fetch, decode/operand fetch, execute, write-back) that has no forwarding paths. Each cycle it compares the source register addresses of the instruction in decode with the destination of the instruction in execute. When a read-after-write dependency exists, it holds the program counter and the fetch/decode register for one cycle and pushes a bubble into the decode/execute register. When execute reports a taken branch, it clears the fetch/decode and decode/execute registers. The two younger instructions become no-operation bubbles, and the branch costs two issue slots.

The controller keeps its own record of which of the decode and execute slots hold real instructions. Signals reported by a slot it knows to be a bubble are ignored. This record covers the cycles after reset, the cycle after a stall, and the two cycles after a flush. A zeroed stage register is assumed to decode as a no-operation with register write and memory write deasserted. Register address 0 is the hardwired zero register and never creates a dependency.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: While `rst` is high, at every clock edge all five outputs (`pcHold`, `ifDofHold`, `dofExBubble`, `ifClear`, `dofClear`) are 0, whatever the other inputs are.
- R2: With the execute slot valid, `exWrEn`=1, `exDstAddr` nonzero, `srcAUse`=1 and `srcAAddr`==`exDstAddr`, and no taken branch, `pcHold`, `ifDofHold` and `dofExBubble` are 1 in that same cycle and both clear outputs are 0.
- R3: The same stall as in R2 is raised through the B operand: `srcBUse`=1 and `srcBAddr`==`exDstAddr`.
- R4: No stall is raised when `exDstAddr` is 0, when `exWrEn` is 0, or when the matching operand's use flag is 0.
- R5: With the execute slot valid and `exBranchTaken`=1, `ifClear` and `dofClear` are 1 in that cycle.
- R6: When a taken branch and a dependency occur in the same cycle, only the clears are raised, and all three hold/bubble outputs stay 0.
- R7: A stall lasts exactly one cycle. In the cycle after a stall, the execute slot holds a bubble, so no output is raised whatever the execute inputs are.
- R8: In the two cycles after a flush, both slots are bubbles and no output is raised. In the third cycle the branch target is in execute and is acted on again.
- R9: After reset is released, the execute slot is treated as empty until two clock edges with `rst` low have passed, so no output is raised before then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| srcAAddr | input | 3 | A-operand register address of the decode instruction |
| srcAUse | input | 1 | Decode instruction reads the A operand |
| srcBAddr | input | 3 | B-operand register address of the decode instruction |
| srcBUse | input | 1 | Decode instruction reads the B operand |
| exDstAddr | input | 3 | Destination register of the execute instruction |
| exWrEn | input | 1 | Execute instruction writes the register file |
| exBranchTaken | input | 1 | Execute resolved a taken branch |
| pcHold | output | 1 | Keep the program counter unchanged |
| ifDofHold | output | 1 | Keep the fetch/decode register unchanged |
| dofExBubble | output | 1 | Load a no-operation into the decode/execute register |
| ifClear | output | 1 | Zero the fetch/decode register |
| dofClear | output | 1 | Zero the decode/execute register |

## Verification
Faults in the slot-validity record are the main concern. If the execute-valid bit fails to drop after a stall, a second stall appears one cycle later. If the bit recovers too early after a flush, a spurious clear appears within the two shadow cycles. Both faults show up at the outputs within one to three cycles of the triggering event. The bench therefore drives hazardous and branch inputs continuously through every shadow cycle, so a stale validity bit becomes visible at once. It also exercises the priority case and each condition that blocks a dependency.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  localparam int REG_ADDR_W = 3;
  localparam int SRC_PORTS  = 2;

  typedef struct packed {
    logic stall;
    logic flush;
  } ctlStrobes_t;

endpackage

// File: rtl/hzd_datapath.sv
module hzd_datapath #(
  parameter int ADDR_W  = hzd_pkg::REG_ADDR_W,
  parameter int NUM_SRC = hzd_pkg::SRC_PORTS
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_SRC-1:0][ADDR_W-1:0]   srcAddr,
  input  logic [NUM_SRC-1:0]               srcUse,
  input  logic [ADDR_W-1:0]                exDstAddr,
  input  logic                             exWrEn,
  input  hzd_pkg::ctlStrobes_t             strobes,
  output logic                             rawHazard,
  output logic                             pcHold,
  output logic                             ifDofHold,
  output logic                             dofExBubble,
  output logic                             ifClear,
  output logic                             dofClear
);

  localparam logic [ADDR_W-1:0] ZERO_REG = '0;

  logic dstLive;
  logic [NUM_SRC-1:0] matchVec;

  // Destination only counts when it is written and is not the zero register
  assign dstLive = exWrEn && (exDstAddr != ZERO_REG);

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : gSrcCmp
      assign matchVec[i] = dstLive && srcUse[i] && (srcAddr[i] == exDstAddr);
    end
  endgenerate

  assign rawHazard = |matchVec;

  // Fan the control strobes out to the stage-register controls
  assign pcHold      = strobes.stall;
  assign ifDofHold   = strobes.stall;
  assign dofExBubble = strobes.stall;
  assign ifClear     = strobes.flush;
  assign dofClear    = strobes.flush;

  // R4: a write to the zero register or no write at all never stalls
  assert_zero_dst_R4: assert property (@(posedge clk) disable iff (rst)
    ((exDstAddr == ZERO_REG) || !exWrEn) |-> !pcHold);

  // R6: clears and holds are never raised together
  assert_flush_wins_R6: assert property (@(posedge clk) disable iff (rst)
    ifClear |-> (!pcHold && !dofExBubble));

endmodule

// File: rtl/hzd_control.sv
module hzd_control (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rawHazard,
  input  logic                 exBranchTaken,
  output hzd_pkg::ctlStrobes_t strobes
);

  logic dofValid;
  logic exValid;
  logic flushNow;
  logic stallNow;

  // Branch flush outranks the dependency stall
  assign flushNow = !rst && exValid && exBranchTaken;
  assign stallNow = !rst && exValid && dofValid && rawHazard && !flushNow;

  assign strobes.flush = flushNow;
  assign strobes.stall = stallNow;

  // Track which slots hold real instructions
  always_ff @(posedge clk) begin
    if (rst) begin
      dofValid <= 1'b0;
      exValid  <= 1'b0;
    end else if (flushNow) begin
      dofValid <= 1'b0;
      exValid  <= 1'b0;
    end else if (stallNow) begin
      exValid  <= 1'b0;
    end else begin
      exValid  <= dofValid;
      dofValid <= 1'b1;
    end
  end

  // R1: nothing raised while reset is high
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |-> !(strobes.stall || strobes.flush));

  // R7: the cycle after a stall is quiet
  assert_stall_single_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.stall |=> !(strobes.stall || strobes.flush));

  // R8: first shadow cycle after a flush is quiet
  assert_flush_shadow1_R8: assert property (@(posedge clk) disable iff (rst)
    strobes.flush |=> !(strobes.stall || strobes.flush));

  // R8: second shadow cycle after a flush is quiet
  assert_flush_shadow2_R8: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.flush, 2) |-> !(strobes.stall || strobes.flush));

  // R9: first cycle after reset release is quiet
  assert_post_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !(strobes.stall || strobes.flush));

endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
  parameter int ADDR_W = hzd_pkg::REG_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] srcAAddr,
  input  logic              srcAUse,
  input  logic [ADDR_W-1:0] srcBAddr,
  input  logic              srcBUse,
  input  logic [ADDR_W-1:0] exDstAddr,
  input  logic              exWrEn,
  input  logic              exBranchTaken,
  output logic              pcHold,
  output logic              ifDofHold,
  output logic              dofExBubble,
  output logic              ifClear,
  output logic              dofClear
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][ADDR_W-1:0] srcAddrVec;
  logic [NUM_SRC-1:0]             srcUseVec;
  logic                           rawHazard;
  hzd_pkg::ctlStrobes_t           strobes;

  assign srcAddrVec = {srcBAddr, srcAAddr};
  assign srcUseVec  = {srcBUse, srcAUse};

  hzd_control u_ctl (
    .clk           (clk),
    .rst           (rst),
    .rawHazard     (rawHazard),
    .exBranchTaken (exBranchTaken),
    .strobes       (strobes)
  );

  hzd_datapath #(
    .ADDR_W  (ADDR_W),
    .NUM_SRC (NUM_SRC)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .srcAddr     (srcAddrVec),
    .srcUse      (srcUseVec),
    .exDstAddr   (exDstAddr),
    .exWrEn      (exWrEn),
    .strobes     (strobes),
    .rawHazard   (rawHazard),
    .pcHold      (pcHold),
    .ifDofHold   (ifDofHold),
    .dofExBubble (dofExBubble),
    .ifClear     (ifClear),
    .dofClear    (dofClear)
  );

  // R2 and R3: a hold always traces back to a live operand match
  assert_stall_cause_R2: assert property (@(posedge clk) disable iff (rst)
    pcHold |-> (exWrEn && (exDstAddr != '0) &&
                ((srcAUse && srcAAddr == exDstAddr) ||
                 (srcBUse && srcBAddr == exDstAddr))));

  // R5: a clear always traces back to a taken branch
  assert_flush_cause_R5: assert property (@(posedge clk) disable iff (rst)
    (ifClear || dofClear) |-> exBranchTaken);

endmodule

// File: tb/pipe_hazard_ctl_test.sv
module pipe_hazard_ctl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] srcAAddr = '0;
  logic       srcAUse = 1'b0;
  logic [2:0] srcBAddr = '0;
  logic       srcBUse = 1'b0;
  logic [2:0] exDstAddr = '0;
  logic       exWrEn = 1'b0;
  logic       exBranchTaken = 1'b0;
  logic       pcHold, ifDofHold, dofExBubble, ifClear, dofClear;

  int vecCount  = 0;
  int missCount = 0;
  bit finished  = 0;

  logic [4:0] expQ[$];
  string      tagQ[$];

  // Reference slot state derived from the requirements
  bit refDofV = 0;
  bit refExV  = 0;

  always #10 clk = ~clk;  // 50 MHz

  pipe_hazard_ctl uut (
    .clk(clk), .rst(rst),
    .srcAAddr(srcAAddr), .srcAUse(srcAUse),
    .srcBAddr(srcBAddr), .srcBUse(srcBUse),
    .exDstAddr(exDstAddr), .exWrEn(exWrEn), .exBranchTaken(exBranchTaken),
    .pcHold(pcHold), .ifDofHold(ifDofHold), .dofExBubble(dofExBubble),
    .ifClear(ifClear), .dofClear(dofClear)
  );

  // Driver: apply one cycle of stimulus and push the expected outputs
  task automatic step(input bit r, input logic [2:0] a, input bit ua,
                      input logic [2:0] b, input bit ub,
                      input logic [2:0] d, input bit we, input bit br,
                      input string tag);
    bit fl, st, hz;
    @(negedge clk);
    rst = r; srcAAddr = a; srcAUse = ua; srcBAddr = b; srcBUse = ub;
    exDstAddr = d; exWrEn = we; exBranchTaken = br;
    hz = we && (d != 3'd0) && ((ua && a == d) || (ub && b == d));
    fl = !r && refExV && br;
    st = !r && refExV && refDofV && hz && !fl;
    expQ.push_back({st, st, st, fl, fl});
    tagQ.push_back(tag);
    if (r || fl) begin
      refDofV = 0; refExV = 0;
    end else if (st) begin
      refExV = 0;
    end else begin
      refExV = refDofV; refDofV = 1;
    end
  endtask

  // Monitor: compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (expQ.size() > 0) begin
        logic [4:0] e, got;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        got = {pcHold, ifDofHold, dofExBubble, ifClear, dofClear};
        vecCount++;
        if (got !== e) begin
          missCount++;
          $display("FAIL %s: outputs {pcHold,ifDofHold,dofExBubble,ifClear,dofClear} actual %b expected %b",
                   t, got, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 20);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    // R1: reset holds everything low even with hazards presented
    step(1, 3'd2, 1, 3'd3, 1, 3'd2, 1, 1, "R1 reset quiet");
    step(1, 3'd2, 1, 3'd3, 1, 3'd3, 1, 1, "R1 reset quiet");
    step(1, 3'd5, 1, 3'd5, 1, 3'd5, 1, 0, "R1 reset quiet");
    // R9: two quiet cycles after release
    step(0, 3'd2, 1, 3'd0, 0, 3'd2, 1, 1, "R9 post-reset cycle 1");
    step(0, 3'd2, 1, 3'd0, 0, 3'd2, 1, 1, "R9 post-reset cycle 2");
    // R2: A-operand dependency
    step(0, 3'd4, 1, 3'd1, 0, 3'd4, 1, 0, "R2 A-operand stall");
    // R7: next cycle quiet despite hazard and branch inputs
    step(0, 3'd4, 1, 3'd4, 1, 3'd4, 1, 1, "R7 post-stall quiet");
    // R3: B-operand dependency
    step(0, 3'd1, 0, 3'd6, 1, 3'd6, 1, 0, "R3 B-operand stall");
    step(0, 3'd6, 1, 3'd6, 1, 3'd6, 1, 0, "R7 post-stall quiet");
    step(0, 3'd1, 1, 3'd2, 1, 3'd3, 1, 0, "R2 no match no stall");
    // R4: blocking conditions
    step(0, 3'd0, 1, 3'd0, 1, 3'd0, 1, 0, "R4 zero register");
    step(0, 3'd5, 0, 3'd5, 0, 3'd5, 1, 0, "R4 use flags low");
    step(0, 3'd5, 1, 3'd5, 1, 3'd5, 0, 0, "R4 write disabled");
    // R5: taken branch
    step(0, 3'd1, 0, 3'd1, 0, 3'd7, 0, 1, "R5 branch flush");
    // R8: two shadow cycles
    step(0, 3'd3, 1, 3'd3, 1, 3'd3, 1, 1, "R8 shadow cycle 1");
    step(0, 3'd3, 1, 3'd3, 1, 3'd3, 1, 1, "R8 shadow cycle 2");
    // R6: branch and dependency together, target now in execute
    step(0, 3'd3, 1, 3'd3, 1, 3'd3, 1, 1, "R6 flush beats stall");
    step(0, 3'd2, 1, 3'd2, 1, 3'd2, 1, 0, "R8 shadow cycle 1");
    step(0, 3'd2, 1, 3'd2, 1, 3'd2, 1, 0, "R8 shadow cycle 2");
    // Both operands match
    step(0, 3'd7, 1, 3'd7, 1, 3'd7, 1, 0, "R3 both operands stall");
    step(0, 3'd7, 1, 3'd7, 1, 3'd7, 1, 0, "R7 post-stall quiet");
    step(0, 3'd0, 0, 3'd0, 0, 3'd0, 0, 1, "R5 branch flush");
    step(0, 3'd0, 0, 3'd0, 0, 3'd0, 0, 0, "R8 shadow cycle 1");
    step(0, 3'd0, 0, 3'd0, 0, 3'd0, 0, 0, "R8 shadow cycle 2");
    step(0, 3'd4, 1, 3'd0, 0, 3'd4, 1, 0, "R8 target acted on");
    // Mid-run reset
    step(1, 3'd4, 1, 3'd0, 0, 3'd4, 1, 1, "R1 reset quiet");
    step(0, 3'd4, 1, 3'd0, 0, 3'd4, 1, 1, "R9 post-reset cycle 1");
    step(0, 3'd4, 1, 3'd0, 0, 3'd4, 1, 1, "R9 post-reset cycle 2");
    step(0, 3'd4, 1, 3'd0, 0, 3'd4, 1, 1, "R5 branch after reset");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule